// File: doc/BRIEF.md
# Bisection Solver for Inverse-Square Distance

This block recovers a distance-like value D from a reading Y that falls off with the square of D, with Y·D² = K for a known constant K. Given a 16-bit scale Y and a target K, it returns the largest integer D for which Y·D² does not exceed K. It never computes a reciprocal or a square root. It fixes the bits of D one at a time, starting from the most significant bit. For each bit it forms the trial value with that bit set, squares the trial, scales the square by Y and compares the result against K.

Both products use a single shift-add multiplier that retires one multiplier bit per clock. The block therefore uses a small amount of logic and many cycles. A caller pulses `start` with Y and K on the inputs. `busy` stays high while the search runs. A one-cycle `done` pulse then presents D on `d_out`, and D holds there until the next result. A zero scale has no finite answer. In that case the block saturates D and raises `ovf`.

Top module: `kd_bisect_solver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done` and `ovf` are 0 and `d_out` is 0.
- R2: For a nonzero `scale_y`, the `d_out` presented with `done` is the largest 16-bit integer D with `scale_y`·D² ≤ `k_target`. K is compared zero-extended to 48 bits.
- R3: The comparison is not strict. A product equal to K keeps the trial bit, and a K one below that product clears it (for example Y=3: K=30000 gives 100 and K=29999 gives 99).
- R4: A start with `scale_y` equal to 0 sets `d_out` to all ones (16'hFFFF) and `ovf` to 1, and pulses `done` on the clock edge that accepts the start. `busy` stays low throughout. A start with a nonzero scale leaves `ovf` at 0 with its result.
- R5: With a nonzero scale, `busy` is high from the edge that accepts the start until `done`. `done` rises exactly 576 clock edges after the accepting edge (16 bits × 2 products × 18 cycles).
- R6: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R7: The block captures Y and K at the accepting edge. While `busy` is high, changes on `scale_y`, `k_target` and `start` change neither the result nor the latency.
- R8: Between `done` pulses, `d_out` and `ovf` keep their values, whatever happens on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a solve; accepted only when not busy |
| scale_y | input | 16 | Measured scale Y |
| k_target | input | 32 | Constant K |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| d_out | output | 16 | Result D, held until the next result |
| ovf | output | 1 | Set with an all-ones result when Y was 0 |

## Verification
The hardest situation to reach from the ports is a second start, together with new operands, arriving in the middle of a search. Input capture and start rejection can only be seen through the eventual result and its timing. The stimulus issues a start with new Y and K about a hundred cycles into a run. It then checks that the result and the 576-cycle latency still match the original operands. Boundary vectors place Y·D² exactly on K and one below it, so each trial-bit decision is tested at the point where the comparison flips.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQ_GO,
    ST_SQ_WAIT,
    ST_SC_GO,
    ST_SC_WAIT
  } kd_state_t;
endpackage

// File: rtl/kd_shiftadd_mul.sv
// Serial shift-add multiplier: one multiplier bit per clock.
module kd_shiftadd_mul #(
  parameter int AW = 32,
  parameter int BW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] prod,
  output logic             fin
);
  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic [PW-1:0] acc, mcand;
  logic [BW-1:0] mplier;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc    <= '0;
        mcand  <= {{BW{1'b0}}, a};
        mplier <= b;
        cnt    <= '0;
        run    <= 1'b1;
      end else if (run) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(BW - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/kd_trial_reg.sv
// Holds the trial value and the mask of the bit under test.
module kd_trial_reg #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          step,
  input  logic          over,
  output logic [NW-1:0] trial,
  output logic [NW-1:0] kept,
  output logic          last
);
  localparam logic [NW-1:0] TOP_BIT = {1'b1, {(NW-1){1'b0}}};

  logic [NW-1:0] mask;

  assign kept = over ? (trial & ~mask) : trial;
  assign last = mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      trial <= '0;
    end else if (init) begin
      mask  <= TOP_BIT;
      trial <= TOP_BIT;
    end else if (step) begin
      trial <= kept | (mask >> 1);
      mask  <= mask >> 1;
    end
  end
endmodule

// File: rtl/kd_bisect_solver.sv
module kd_bisect_solver #(
  parameter int NW = 16,
  parameter int KW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] scale_y,
  input  logic [KW-1:0] k_target,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] d_out,
  output logic          ovf
);
  import kd_pkg::*;

  localparam int SQW = 2 * NW;
  localparam int PW  = SQW + NW;

  kd_state_t      state;
  logic [NW-1:0]  y_q;
  logic [KW-1:0]  k_q;
  logic [SQW-1:0] sq_q;
  logic [PW-1:0]  prod, k_ext;
  logic [SQW-1:0] mul_a;
  logic [NW-1:0]  mul_b, trial, kept;
  logic           mul_go, fin, over, last, t_init, t_step;

  assign k_ext  = {{(PW-KW){1'b0}}, k_q};
  assign over   = prod > k_ext;
  assign mul_go = (state == ST_SQ_GO) || (state == ST_SC_GO);
  assign mul_a  = (state == ST_SC_GO) ? sq_q : {{NW{1'b0}}, trial};
  assign mul_b  = (state == ST_SC_GO) ? y_q  : trial;
  assign t_init = (state == ST_IDLE) && start && (scale_y != '0);
  assign t_step = (state == ST_SC_WAIT) && fin && !last;
  assign busy   = (state != ST_IDLE);

  kd_shiftadd_mul #(.AW(SQW), .BW(NW)) i_mul (
    .clk(clk), .rst(rst), .go(mul_go), .a(mul_a), .b(mul_b),
    .prod(prod), .fin(fin)
  );

  kd_trial_reg #(.NW(NW)) i_trial (
    .clk(clk), .rst(rst), .init(t_init), .step(t_step), .over(over),
    .trial(trial), .kept(kept), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      y_q   <= '0;
      k_q   <= '0;
      sq_q  <= '0;
      d_out <= '0;
      ovf   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (scale_y == '0) begin
              d_out <= '1;
              ovf   <= 1'b1;
              done  <= 1'b1;
            end else begin
              y_q   <= scale_y;
              k_q   <= k_target;
              state <= ST_SQ_GO;
            end
          end
        end
        ST_SQ_GO:   state <= ST_SQ_WAIT;
        ST_SQ_WAIT: begin
          if (fin) begin
            sq_q  <= prod[SQW-1:0];
            state <= ST_SC_GO;
          end
        end
        ST_SC_GO:   state <= ST_SC_WAIT;
        ST_SC_WAIT: begin
          if (fin) begin
            if (last) begin
              d_out <= kept;
              ovf   <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_SQ_GO;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kd_bisect_solver_chk.sv
module kd_bisect_solver_chk #(
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [NW-1:0] scale_y,
  input logic          busy,
  input logic          done,
  input logic [NW-1:0] d_out,
  input logic          ovf
);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r4_zero_scale: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && scale_y == '0) |=> (done && ovf && d_out == '1));

  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(d_out) && $stable(ovf)));
endmodule

bind kd_bisect_solver kd_bisect_solver_chk #(.NW(NW)) i_chk (
  .clk(clk), .rst(rst), .start(start), .scale_y(scale_y),
  .busy(busy), .done(done), .d_out(d_out), .ovf(ovf)
);

// File: tb/test_kd_bisect_solver.sv
module test_kd_bisect_solver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] scale_y = '0;
  logic [31:0] k_target = '0;
  logic        busy, done, ovf;
  logic [15:0] d_out;

  int vectors = 0;
  int fails   = 0;
  localparam int LAT = 576;

  always #10 clk = ~clk;

  kd_bisect_solver i_kd_bisect_solver (
    .clk(clk), .rst(rst), .start(start), .scale_y(scale_y),
    .k_target(k_target), .busy(busy), .done(done), .d_out(d_out), .ovf(ovf)
  );

  localparam int NV = 15;
  localparam logic [15:0] TY [NV] = '{16'd1, 16'd1, 16'd1, 16'd1, 16'd3,
    16'd3, 16'd1, 16'd65535, 16'd65535, 16'd65535, 16'd7, 16'd2, 16'd100,
    16'd1, 16'd1};
  localparam logic [31:0] TK [NV] = '{32'd0, 32'd1, 32'd3, 32'd4, 32'd30000,
    32'd29999, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd65534, 32'd65535,
    32'd1000000, 32'h80000000, 32'd12345678, 32'hFFFE0001, 32'hFFFE0000};
  localparam logic [15:0] TD [NV] = '{16'd0, 16'd1, 16'd1, 16'd2, 16'd100,
    16'd99, 16'd65535, 16'd256, 16'd0, 16'd1, 16'd377, 16'd32768, 16'd351,
    16'd65535, 16'd65534};

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [15:0] y, input logic [31:0] k);
    @(negedge clk);
    start = 1'b1; scale_y = y; k_target = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !ovf && d_out == 0, "R1", {busy, done, ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ovf && d_out == 0, "R1 after release", d_out, 0);

    // R4: zero scale saturates immediately
    launch(16'd0, 32'd123);
    chk(done && !busy, "R4 done on accept", {done, busy}, 2);
    chk(d_out == 16'hFFFF, "R4 d_out", d_out, 16'hFFFF);
    chk(ovf, "R4 ovf", ovf, 1);
    @(negedge clk);
    chk(!done, "R6 pulse width", done, 0);

    // R2, R3, R5, R6: vector table
    for (int i = 0; i < NV; i++) begin
      launch(TY[i], TK[i]);
      chk(busy, "R5 busy after accept", busy, 1);
      wait_done(n);
      chk(n == LAT, "R5 latency", n, LAT);
      chk(!busy, "R6 busy low with done", busy, 0);
      chk(d_out == TD[i], (i == 4 || i == 5 || i > 12) ? "R3 boundary" : "R2 result",
          d_out, TD[i]);
      chk(!ovf, "R4 ovf clear on nonzero scale", ovf, 0);
      @(negedge clk);
      chk(!done, "R6 pulse width", done, 0);
    end

    // R7: inputs and start ignored while busy
    launch(16'd3, 32'd30000);
    n = 0;
    while (!done && n < 2000) begin
      if (n == 100) begin
        scale_y = 16'd5; k_target = 32'd7; start = 1'b1;
      end else if (n == 101) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == LAT, "R7 latency unchanged", n, LAT);
    chk(d_out == 16'd100, "R7 result from captured operands", d_out, 100);

    // R8: result held while idle inputs change
    @(negedge clk);
    scale_y = 16'd0; k_target = 32'd9;
    repeat (50) @(negedge clk);
    chk(d_out == 16'd100 && !ovf && !done, "R8 hold", d_out, 100);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule